// File: doc/BRIEF.md
# Multi-Lane Hit Word Serializer

This block takes hit records from a readout core and turns each one into a fixed 24-bit frame. A frame is a 4-bit header followed by the 20-bit hit payload. The frame is sent over a group of serial lanes, and the number of lanes is chosen at run time: 1, 2, 4 or 6. Each lane carries two bits per readout clock, one for the rising edge and one for the falling edge. The output is modelled as a pair of bits per lane in each clock. With six lanes the frame takes two clocks; with one lane it takes twelve.

Records arrive on a valid/ready stream. A record is taken only at a frame boundary. When no record is offered at a boundary, the block sends an idle frame, so the lanes always carry framed data. A frame marker is high during the first clock of every frame. A change to the lane-count input is read only at a frame boundary. Lanes that the current frame does not use are driven low.

Top module: `hit_lane_serializer`

## Requirements
- R1: While `rst` is high, `in_ready`, `frame_mark` and every bit of `lane_bits` are 0. Until the first frame appears after reset, `lane_bits` and `frame_mark` stay 0.
- R2: A record accepted at a boundary is sent as the 24-bit frame {4'b1010, amp[2:0], set[4:0], strip[3:0], stamp[7:0]}. Frame bit 23 is sent first.
- R3: When `in_valid` is low at a boundary, the next frame is the idle frame {4'b0101, 20'b0}.
- R4: `lane_sel` selects the lane count: 0 gives 1 lane, 1 gives 2, 2 gives 4 and 3 gives 6. Call the lane count L. Frame bits are counted in send order from i=0, which is bit 23. In beat k, lane j sends bit 2Lk+j on `lane_bits[2j+1]` (rising edge) and bit 2Lk+L+j on `lane_bits[2j]` (falling edge).
- R5: A frame lasts 24/(2L) clocks: 12, 6, 3 or 2. `frame_mark` is high in the first clock of each frame and low in all other clocks of that frame.
- R6: `in_ready` is high only in the last clock before a new frame starts. This is the last beat of the current frame, or the first clock after reset. A record offered while `in_ready` is low is not taken and has no effect on the output.
- R7: `lane_sel` is sampled only in the clock where `in_ready` is high. Changing it in any other clock does not change the frame that is being sent.
- R8: Lanes j >= L carry 0 on both of their bits for the whole frame.
- R9: Frames follow each other with no gap. The first beat of the next frame comes in the clock right after the last beat of the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A hit record is offered |
| in_ready | output | 1 | Frame boundary; an offered record is taken at this edge |
| hit_amp | input | 3 | Pulse amplitude code |
| hit_set | input | 5 | Logic set number |
| hit_strip | input | 4 | Strip number within the set |
| hit_stamp | input | 8 | Time stamp of the hit |
| lane_sel | input | 2 | Lane-count code (0:1, 1:2, 2:4, 3:6) |
| lane_bits | output | 12 | Per lane j: [2j+1] rising-edge bit, [2j] falling-edge bit |
| frame_mark | output | 1 | High in the first clock of each frame |

## Verification
The assertions assume that `lane_sel` holds one of the four codes, so every lane count they derive is 1, 2, 4 or 6. They also assume that reset lasts at least one clock before the stream starts. The bench only ever drives two-bit lane codes. It holds each record stable with `in_valid` high until the boundary takes it. During the lane-change test it changes `lane_sel` freely between boundaries, so the assertions see changes in the middle of a frame. Those changes are legal input, and the assertions read the code only at the `in_ready` edge.

// File: rtl/hls_pkg.sv
package hls_pkg;
  localparam int HDR_W    = 4;
  localparam int AMP_W    = 3;
  localparam int SET_W    = 5;
  localparam int STRIP_W  = 4;
  localparam int STAMP_W  = 8;
  localparam int PAY_W    = AMP_W + SET_W + STRIP_W + STAMP_W;
  localparam int FRAME_W  = HDR_W + PAY_W;
  localparam int LANES_MAX = 6;
  localparam int SEL_W    = 2;
  localparam int BEAT_W   = $clog2(FRAME_W / 2 + 1);

  localparam logic [HDR_W-1:0] HDR_HIT  = 4'b1010;
  localparam logic [HDR_W-1:0] HDR_IDLE = 4'b0101;

  typedef struct packed {
    logic [AMP_W-1:0]   amp;
    logic [SET_W-1:0]   set_no;
    logic [STRIP_W-1:0] strip;
    logic [STAMP_W-1:0] stamp;
  } hit_t;

  // lane count coded by the two-bit setting
  function automatic int lanes_of(input logic [SEL_W-1:0] s);
    case (s)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return LANES_MAX;
    endcase
  endfunction

  // clocks per frame at two bits per lane per clock
  function automatic int beats_of(input logic [SEL_W-1:0] s);
    return FRAME_W / (2 * lanes_of(s));
  endfunction
endpackage

// File: rtl/hls_frame_builder.sv
module hls_frame_builder
  import hls_pkg::*;
(
  input  logic               take,
  input  hit_t               hit,
  output logic [FRAME_W-1:0] word
);
  always_comb begin
    if (take) word = {HDR_HIT, hit};
    else      word = {HDR_IDLE, {PAY_W{1'b0}}};
  end
endmodule

// File: rtl/hls_lane_map.sv
module hls_lane_map
  import hls_pkg::*;
(
  input  logic [FRAME_W-1:0]     word,
  input  logic [SEL_W-1:0]       sel,
  output logic [2*LANES_MAX-1:0] bits
);
  logic [3:0] nl;
  assign nl = 4'(lanes_of(sel));

  for (genvar j = 0; j < LANES_MAX; j++) begin : g_lane
    logic rise_b, fall_b;
    always_comb begin
      rise_b = 1'b0;
      fall_b = 1'b0;
      if (j < int'(nl)) begin
        rise_b = word[FRAME_W-1-j];
        fall_b = word[FRAME_W-1-j-int'(nl)];
      end
    end
    assign bits[2*j+1] = rise_b;
    assign bits[2*j]   = fall_b;
  end
endmodule

// File: rtl/hls_frame_ctrl.sv
module hls_frame_ctrl
  import hls_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] lane_sel,
  output logic             load,
  output logic [SEL_W-1:0] sel_q
);
  logic [BEAT_W-1:0] left_q;

  assign load = !rst && (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      sel_q  <= '0;
    end else if (load) begin
      left_q <= BEAT_W'(beats_of(lane_sel) - 1);
      sel_q  <= lane_sel;
    end else begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/hit_lane_serializer.sv
module hit_lane_serializer
  import hls_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [AMP_W-1:0]       hit_amp,
  input  logic [SET_W-1:0]       hit_set,
  input  logic [STRIP_W-1:0]     hit_strip,
  input  logic [STAMP_W-1:0]     hit_stamp,
  input  logic [SEL_W-1:0]       lane_sel,
  output logic [2*LANES_MAX-1:0] lane_bits,
  output logic                   frame_mark
);
  hit_t                   hit_in;
  logic                   load;
  logic [SEL_W-1:0]       sel_q;
  logic [SEL_W-1:0]       cur_sel;
  logic [FRAME_W-1:0]     frame_new;
  logic [FRAME_W-1:0]     sr_q;
  logic [FRAME_W-1:0]     src;
  logic [2*LANES_MAX-1:0] mapped;

  assign hit_in   = {hit_amp, hit_set, hit_strip, hit_stamp};
  assign in_ready = load;

  hls_frame_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .lane_sel (lane_sel),
    .load     (load),
    .sel_q    (sel_q)
  );

  hls_frame_builder u_build (
    .take (in_valid & load),
    .hit  (hit_in),
    .word (frame_new)
  );

  assign src     = load ? frame_new : sr_q;
  assign cur_sel = load ? lane_sel  : sel_q;

  hls_lane_map u_map (
    .word (src),
    .sel  (cur_sel),
    .bits (mapped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q       <= '0;
      lane_bits  <= '0;
      frame_mark <= 1'b0;
    end else begin
      lane_bits  <= mapped;
      frame_mark <= load;
      sr_q       <= src << (2 * lanes_of(cur_sel));
    end
  end
endmodule

// File: rtl/hls_serializer_chk.sv
module hls_serializer_chk
  import hls_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic                   in_ready,
  input logic [SEL_W-1:0]       lane_sel,
  input logic [2*LANES_MAX-1:0] lane_bits,
  input logic                   frame_mark
);
  logic [SEL_W-1:0]       sel_seen;
  logic                   started;
  logic [4:0]             cnt;
  logic [4:0]             beat_idx;
  logic [2*LANES_MAX-1:0] used;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_seen <= '0;
      started  <= 1'b0;
      cnt      <= '0;
    end else begin
      if (in_ready) begin
        sel_seen <= lane_sel;
        started  <= 1'b1;
      end
      cnt <= frame_mark ? 5'd1 : cnt + 5'd1;
    end
  end

  assign beat_idx = frame_mark ? 5'd0 : cnt;

  always_comb begin
    used = '0;
    for (int k = 0; k < LANES_MAX; k++)
      if (k < lanes_of(sel_seen)) used[2*k +: 2] = 2'b11;
  end

  always @(posedge clk)
    if (rst) AST_IDLE_IN_RESET: assert (!in_ready); // R1

  AST_MARK_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> frame_mark); // R5

  AST_NO_MARK_WITHOUT_READY: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> !frame_mark); // R6

  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (started && in_ready) |-> (int'(beat_idx) == beats_of(sel_seen) - 1)); // R5

  AST_UNUSED_LANES_LOW: assert property (@(posedge clk) disable iff (rst)
    started |-> ((lane_bits & ~used) == '0)); // R8
endmodule

bind hit_lane_serializer hls_serializer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .lane_sel   (lane_sel),
  .lane_bits  (lane_bits),
  .frame_mark (frame_mark)
);

// File: tb/sim_hit_lane_serializer.sv
`timescale 1ns/1ps
module sim_hit_lane_serializer;
  import hls_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  hit_amp = '0;
  logic [4:0]  hit_set = '0;
  logic [3:0]  hit_strip = '0;
  logic [7:0]  hit_stamp = '0;
  logic [1:0]  lane_sel = '0;
  logic [11:0] lane_bits;
  logic        frame_mark;

  always #2.5 clk = ~clk;

  hit_lane_serializer u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .hit_amp(hit_amp), .hit_set(hit_set), .hit_strip(hit_strip),
    .hit_stamp(hit_stamp), .lane_sel(lane_sel), .lane_bits(lane_bits),
    .frame_mark(frame_mark)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string scen = "";

  // bench model of the frame on the lanes
  logic [23:0] m_frame = '0;
  bit          m_hit = 0;
  bit          m_active = 0;
  int          m_L = 1;
  int          m_nb = 12;
  int          m_beat = 0;
  logic [19:0] lf = 20'h5A3C1;

  function automatic int lanes_b(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 6;
  endfunction

  function automatic logic [11:0] exp_bits(input logic [23:0] f, input int L, input int k);
    logic [11:0] b = '0;
    for (int j = 0; j < 6; j++)
      if (j < L) begin
        b[2*j+1] = f[23 - (2*L*k + j)];
        b[2*j]   = f[23 - (2*L*k + L + j)];
      end
    return b;
  endfunction

  function automatic logic [11:0] mask_b(input int L);
    logic [11:0] m = '0;
    for (int j = 0; j < 6; j++) if (j < L) m[2*j +: 2] = 2'b11;
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step_lf();
    lf = {lf[18:0], lf[19] ^ lf[16]};
  endtask

  // called at a falling edge; checks, drives, advances the model
  task automatic tick(input bit v, input logic [19:0] h, input logic [1:0] s, output bit acc);
    logic [11:0] e, m;
    bit rdy_e;
    #1;
    if (!m_active) begin
      chk(lane_bits == '0, "R1 lanes before first frame", 32'(lane_bits), 0);
      chk(frame_mark == 1'b0, "R1 mark before first frame", 32'(frame_mark), 0);
    end else begin
      e = exp_bits(m_frame, m_L, m_beat);
      m = mask_b(m_L);
      chk((lane_bits & m) == e, {m_hit ? "R2 R4 " : "R3 R4 ", scen}, 32'(lane_bits), 32'(e));
      chk((lane_bits & ~m) == '0, "R8 unused lanes", 32'(lane_bits), 32'(e));
      chk(frame_mark == (m_beat == 0), "R5 R9 frame mark", 32'(frame_mark), 32'(m_beat == 0));
    end
    rdy_e = !m_active || (m_beat == m_nb - 1);
    chk(in_ready == rdy_e, "R6 ready at boundary", 32'(in_ready), 32'(rdy_e));
    in_valid  = v;
    {hit_amp, hit_set, hit_strip, hit_stamp} = h;
    lane_sel  = s;
    acc = rdy_e && v;
    if (rdy_e) begin
      m_frame  = v ? {4'b1010, h} : {4'b0101, 20'b0};
      m_hit    = v;
      m_L      = lanes_b(s);
      m_nb     = 12 / m_L;
      m_beat   = 0;
      m_active = 1;
    end else begin
      m_beat++;
    end
    @(negedge clk);
  endtask

  task automatic send(input logic [19:0] h, input logic [1:0] s, input bit wander);
    bit acc = 0;
    while (!acc) begin
      logic [1:0] sel = s;
      if (wander) begin step_lf(); sel = lf[1:0]; end
      tick(1'b1, h, sel, acc);
    end
  endtask

  task automatic idle(input int n, input logic [1:0] s);
    bit acc;
    repeat (n) tick(1'b0, '0, s, acc);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk); #1;
      chk(in_ready == 1'b0, "R1 ready in reset", 32'(in_ready), 0);
      chk(lane_bits == '0 && frame_mark == 1'b0, "R1 outputs in reset", 32'(lane_bits), 0);
    end
    @(negedge clk);
    rst = 1'b0;

    // R9: walking-one payloads back to back at every lane count
    scen = "R9";
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 20; b++) send(20'(1) << b, 2'(s), 1'b0);

    // R3: isolated hits separated by idle frames; corner payloads
    scen = "gap";
    for (int s = 0; s < 4; s++) begin
      send(20'hFFFFF, 2'(s), 1'b0);
      idle(2 * (12 / lanes_b(2'(s))) + 1, 2'(s));
      send(20'h00000, 2'(s), 1'b0);
      idle(5, 2'(s));
    end

    // R7: lane_sel wanders every clock; only boundary value counts
    scen = "R7";
    for (int n = 0; n < 60; n++) begin
      step_lf();
      send(lf, 2'(n), 1'b1);
      if (n % 7 == 0) idle(3, lf[3:2]);
    end

    scen = "tail";
    idle(30, 2'd3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule